// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Walker

This block works through a ring of transmit buffer descriptors held in system memory. When the controller is enabled and a transmit-demand strobe arrives, it fetches the descriptor at its current ring position. If that descriptor is owned by the hardware, the block reads the buffer it points to and streams the bytes out on a valid/ready byte channel. It then writes the descriptor back with the ownership bit cleared and moves on to the next descriptor. A walk ends at the first descriptor that software has not handed over. That descriptor stays the current position, so the next demand resumes from it.

Frames may span several descriptors. A flag on the final descriptor of a frame closes it: the last byte of that buffer carries an end marker, and a frame event pulses. Each descriptor also produces a buffer event. The block keeps a running frame length. When a buffer would push the frame beyond a parameterised limit, the buffer is cut short and a babble event pulses.

All memory traffic goes through one 32-bit request/response port. The port has one request in flight at a time: the block holds a request until it is granted, and reads return later with a valid strobe.

Top module: `txr_ring_walker`

## Requirements
- R1: After reset the block is idle: `walking`, `mem_req`, `tx_valid` and all three event outputs are low.
- R2: A `tx_demand` pulse sampled while `ctrl_en` is high and the block is idle starts a walk, and the first memory request reads the current descriptor address. A demand sampled while `ctrl_en` is low is ignored: no request is made and `walking` stays low.
- R3: Descriptor layout: the 32-bit word at the descriptor address holds the flags in bits 31:16 and the buffer byte count in bits 15:0. The word at address +4 holds the buffer byte address. Within the flags field, ready is bit 15, wrap is bit 13 and last is bit 11.
- R4: When a fetched descriptor has ready clear, the walk ends without writing that descriptor, and the next demand starts by fetching that same descriptor.
- R5: Buffer bytes are sent in increasing address order from any byte alignment. The byte at address A is lane A[1:0] of the word at A with its two low bits cleared, where lane k is bits 8k+7:8k.
- R6: `tx_last` is high on the final byte sent from a descriptor whose last flag is set, and low on every other byte.
- R7: After a descriptor's bytes have been sent, its first word is written back with bit 31 (ready) cleared and every other bit unchanged. `ev_buf_done` pulses for one cycle for each such descriptor, including one with a zero byte count.
- R8: A descriptor with the last flag set pulses `ev_frame_done` together with its `ev_buf_done`, and the running frame length restarts at zero. The running length also restarts at zero at the start of every walk.
- R9: If the running length plus a descriptor's byte count exceeds MAX_FRAME, only MAX_FRAME minus the running length bytes are sent from that buffer, and `ev_babble` pulses together with that descriptor's `ev_buf_done`.
- R10: The next descriptor is 8 bytes after the current one, or the ring base when the current descriptor's wrap flag is set.
- R11: A base write while idle stores the value with its two low bits cleared and moves the current position to it. A base write while walking is ignored.
- R12: Once raised, a memory request keeps its address, direction and write data stable until it is granted. Once offered, an output byte keeps its data and last marker stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_en | input | 1 | Controller enable; demands are accepted only while high |
| tx_demand | input | 1 | Transmit-demand strobe |
| ring_base_wr | input | 1 | Strobe to load the ring base |
| ring_base_val | input | ADDR_W | Ring base value to load |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write when high |
| mem_addr | output | ADDR_W | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| ev_buf_done | output | 1 | Descriptor-completed pulse |
| ev_frame_done | output | 1 | Frame-completed pulse |
| ev_babble | output | 1 | Over-length pulse |
| walking | output | 1 | A walk is in progress |

## Verification
The main function is tried with single-descriptor frames across all four buffer alignments and a range of lengths. These runs separate wrong lane selection and wrong word stepping from correct streaming. The lengths run just below, at and just above the frame limit to pin down where clipping begins. Multi-descriptor rings cover other cases: frames split over buffers, a zero-length buffer, a wrap back to the base, a stop on a descriptor not yet handed over followed by a resume, and a partial frame left at the end of one demand. These cases separate correct pointer advance and length accumulation from off-by-one faults. Randomly stalled grants and ready signals on both channels check that the block holds its requests and bytes steady.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int FLAG_W       = 16;
   localparam int COUNT_W      = 16;
   localparam int WORD_W       = 32;
   localparam int DESC_BYTES   = 8;
   localparam int FLG_READY    = 15;
   localparam int FLG_WRAP     = 13;
   localparam int FLG_LAST     = 11;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR_REQ,
      ST_HDR_WAIT,
      ST_PTR_REQ,
      ST_PTR_WAIT,
      ST_DAT_REQ,
      ST_DAT_WAIT,
      ST_STREAM,
      ST_WBACK
   } txr_state_e;
endpackage

// File: rtl/txr_ptr_unit.sv
module txr_ptr_unit #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              wrap,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] cur_q
);
   import txr_pkg::*;

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
   localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(DESC_BYTES);

   logic [ADDR_W-1:0] aligned_val;
   assign aligned_val = load_val & ALIGN_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= aligned_val;
         cur_q  <= aligned_val;
      end else if (step) begin
         cur_q  <= wrap ? base_q : cur_q + STRIDE;
      end
   end
endmodule

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
   parameter int MAX_FRAME = 2048
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        commit,
   input  logic                        last,
   input  logic [txr_pkg::COUNT_W-1:0] len_in,
   output logic [txr_pkg::COUNT_W-1:0] eff_len,
   output logic                        clip
);
   import txr_pkg::*;

   localparam int ACC_W = $clog2(MAX_FRAME + 1);
   localparam int CMP_W = ((ACC_W > COUNT_W) ? ACC_W : COUNT_W) + 1;

   logic [ACC_W-1:0] acc_q;
   logic [CMP_W-1:0] room;
   logic [CMP_W-1:0] len_ext;
   logic [CMP_W-1:0] acc_sum;

   assign room    = CMP_W'(MAX_FRAME) - CMP_W'(acc_q);
   assign len_ext = CMP_W'(len_in);
   assign clip    = len_ext > room;
   assign eff_len = clip ? room[COUNT_W-1:0] : len_in;
   assign acc_sum = CMP_W'(acc_q) + CMP_W'(eff_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (commit) begin
         acc_q <= last ? '0 : acc_sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/txr_lane_sel.sv
module txr_lane_sel #(
   parameter bit BIG_LANES = 1'b0
) (
   input  logic [31:0] word,
   input  logic [1:0]  lane,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_LANES) begin : g_big
         logic [1:0] flipped;
         assign flipped = ~lane;
         assign byte_o  = word[{flipped, 3'b000} +: 8];
      end else begin : g_little
         assign byte_o  = word[{lane, 3'b000} +: 8];
      end
   endgenerate
endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker #(
   parameter int ADDR_W    = 32,
   parameter int MAX_FRAME = 2048,
   parameter bit BIG_LANES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_en,
   input  logic              tx_demand,
   input  logic              ring_base_wr,
   input  logic [ADDR_W-1:0] ring_base_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              ev_buf_done,
   output logic              ev_frame_done,
   output logic              ev_babble,
   output logic              walking
);
   import txr_pkg::*;

   localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(4);

   generate
      if (ADDR_W < 4 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("txr_ring_walker: ADDR_W must lie in 4..32");
      end
      if (MAX_FRAME < 1 || MAX_FRAME > 65535) begin : g_bad_max
         $error("txr_ring_walker: MAX_FRAME must lie in 1..65535");
      end
   endgenerate

   txr_state_e st_q, st_d;

   logic [FLAG_W-1:0]  d_flags;
   logic [COUNT_W-1:0] d_len;
   logic [COUNT_W-1:0] left_q;
   logic [ADDR_W-1:0]  byte_addr;
   logic [WORD_W-1:0]  word_q;
   logic [ADDR_W-1:0]  base_q;
   logic [ADDR_W-1:0]  cur_q;
   logic [COUNT_W-1:0] eff_len;
   logic               clip;
   logic               start;
   logic               wb_done;
   logic               byte_take;
   logic               ev_buf_q, ev_frame_q, ev_bab_q;

   assign start     = (st_q == ST_IDLE) && tx_demand && ctrl_en;
   assign wb_done   = (st_q == ST_WBACK) && mem_gnt;
   assign byte_take = (st_q == ST_STREAM) && tx_ready;

   txr_ptr_unit #(.ADDR_W(ADDR_W)) ptr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ring_base_wr && (st_q == ST_IDLE)),
      .load_val (ring_base_val),
      .step     (wb_done),
      .wrap     (d_flags[FLG_WRAP]),
      .base_q   (base_q),
      .cur_q    (cur_q)
   );

   txr_len_clip #(.MAX_FRAME(MAX_FRAME)) clip_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .commit  (wb_done),
      .last    (d_flags[FLG_LAST]),
      .len_in  (d_len),
      .eff_len (eff_len),
      .clip    (clip)
   );

   txr_lane_sel #(.BIG_LANES(BIG_LANES)) lane_i (
      .word   (word_q),
      .lane   (byte_addr[1:0]),
      .byte_o (tx_data)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (start)       st_d = ST_HDR_REQ;
         ST_HDR_REQ:  if (mem_gnt)     st_d = ST_HDR_WAIT;
         ST_HDR_WAIT: if (mem_rvalid)  st_d = mem_rdata[16 + FLG_READY] ? ST_PTR_REQ : ST_IDLE;
         ST_PTR_REQ:  if (mem_gnt)     st_d = ST_PTR_WAIT;
         ST_PTR_WAIT: if (mem_rvalid)  st_d = (eff_len == '0) ? ST_WBACK : ST_DAT_REQ;
         ST_DAT_REQ:  if (mem_gnt)     st_d = ST_DAT_WAIT;
         ST_DAT_WAIT: if (mem_rvalid)  st_d = ST_STREAM;
         ST_STREAM: begin
            if (tx_ready) begin
               if (left_q == COUNT_W'(1))       st_d = ST_WBACK;
               else if (byte_addr[1:0] == 2'b11) st_d = ST_DAT_REQ;
            end
         end
         ST_WBACK:    if (mem_gnt)     st_d = ST_HDR_REQ;
         default:                      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         d_flags    <= '0;
         d_len      <= '0;
         left_q     <= '0;
         byte_addr  <= '0;
         word_q     <= '0;
         ev_buf_q   <= 1'b0;
         ev_frame_q <= 1'b0;
         ev_bab_q   <= 1'b0;
      end else begin
         st_q       <= st_d;
         ev_buf_q   <= wb_done;
         ev_frame_q <= wb_done && d_flags[FLG_LAST];
         ev_bab_q   <= wb_done && clip;
         if ((st_q == ST_HDR_WAIT) && mem_rvalid) begin
            d_flags <= mem_rdata[WORD_W-1:COUNT_W];
            d_len   <= mem_rdata[COUNT_W-1:0];
         end
         if ((st_q == ST_PTR_WAIT) && mem_rvalid) begin
            byte_addr <= mem_rdata[ADDR_W-1:0];
            left_q    <= eff_len;
         end
         if ((st_q == ST_DAT_WAIT) && mem_rvalid) begin
            word_q <= mem_rdata;
         end
         if (byte_take) begin
            left_q    <= left_q - COUNT_W'(1);
            byte_addr <= byte_addr + ADDR_W'(1);
         end
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_HDR_REQ: begin
            mem_req  = 1'b1;
            mem_addr = cur_q;
         end
         ST_PTR_REQ: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + PTR_OFS;
         end
         ST_DAT_REQ: begin
            mem_req  = 1'b1;
            mem_addr = {byte_addr[ADDR_W-1:2], 2'b00};
         end
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q;
            mem_wdata = {d_flags & ~(FLAG_W'(1) << FLG_READY), d_len};
         end
         default: ;
      endcase
   end

   assign tx_valid      = (st_q == ST_STREAM);
   assign tx_last       = tx_valid && (left_q == COUNT_W'(1)) && d_flags[FLG_LAST];
   assign ev_buf_done   = ev_buf_q;
   assign ev_frame_done = ev_frame_q;
   assign ev_babble     = ev_bab_q;
   assign walking       = (st_q != ST_IDLE);
endmodule

// File: rtl/txr_walk_chk.sv
module txr_walk_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_en,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_gnt,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              ev_buf_done,
   input logic              ev_frame_done,
   input logic              ev_babble,
   input logic              walking
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !walking |-> (!mem_req && !tx_valid));

   a_r2_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!walking && !ctrl_en) |=> !walking);

   a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r7_wb_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[31]);

   a_r8_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_done |-> ev_buf_done);

   a_r9_babble_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_babble |-> ev_buf_done);

   a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   a_r12_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind txr_ring_walker txr_walk_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctrl_en       (ctrl_en),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_gnt       (mem_gnt),
   .tx_valid      (tx_valid),
   .tx_data       (tx_data),
   .tx_last       (tx_last),
   .tx_ready      (tx_ready),
   .ev_buf_done   (ev_buf_done),
   .ev_frame_done (ev_frame_done),
   .ev_babble     (ev_babble),
   .walking       (walking)
);

// File: tb/txr_ring_walker_tb.sv
`timescale 1ns/1ps
module txr_ring_walker_tb_top;
   localparam int MAXF = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b0;
   logic        tx_demand = 1'b0;
   logic        ring_base_wr = 1'b0;
   logic [31:0] ring_base_val = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        ev_buf_done, ev_frame_done, ev_babble, walking;

   always #2 clk = ~clk;

   txr_ring_walker #(.ADDR_W(32), .MAX_FRAME(MAXF), .BIG_LANES(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_demand(tx_demand),
      .ring_base_wr(ring_base_wr), .ring_base_val(ring_base_val),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done), .ev_babble(ev_babble),
      .walking(walking)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [0:255];
   logic [31:0] sm  [0:255];

   logic [7:0]  cap_data [0:1023];
   logic        cap_last [0:1023];
   int          cap_n;
   logic [7:0]  exp_data [0:1023];
   logic        exp_last [0:1023];
   int          exp_n;
   int          n_buf, n_frame, n_bab;
   int          e_buf, e_frame, e_bab;
   logic [31:0] first_addr, exp_first;
   bit          seen_req, act_seen;
   int          mptr, mbase;

   bit          rd_pend = 1'b0;
   logic [31:0] rd_buf = '0;
   int          gcnt = 0, rcnt = 0;
   bit          stall_q = 1'b0, txst_q = 1'b0;
   logic [31:0] stall_addr, stall_data;
   logic        stall_we, txst_l;
   logic [7:0]  txst_d;
   int          hold_err = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) + 5);
   endfunction

   function automatic int widx(input int a);
      return (a >> 2) & 255;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // memory and stream model, driven away from the active edge
   always @(negedge clk) begin
      if (stall_q && (!mem_req || mem_addr != stall_addr || mem_we != stall_we
                      || mem_wdata != stall_data)) hold_err++;
      if (txst_q && (!tx_valid || tx_data != txst_d || tx_last != txst_l)) hold_err++;
      mem_rvalid = rd_pend;
      mem_rdata  = rd_buf;
      rd_pend    = 1'b0;
      gcnt++;
      mem_gnt = (gcnt % 3) != 0;
      if (mem_req && !seen_req) begin
         first_addr = mem_addr;
         seen_req   = 1'b1;
      end
      if (mem_req && mem_gnt) begin
         if (mem_we) mem[widx(mem_addr)] = mem_wdata;
         else begin
            rd_pend = 1'b1;
            rd_buf  = mem[widx(mem_addr)];
         end
      end
      stall_q = mem_req && !mem_gnt;
      stall_addr = mem_addr; stall_we = mem_we; stall_data = mem_wdata;
      rcnt++;
      tx_ready = (rcnt % 4) != 2;
      if (tx_valid && tx_ready && cap_n < 1024) begin
         cap_data[cap_n] = tx_data;
         cap_last[cap_n] = tx_last;
         cap_n++;
      end
      txst_q = tx_valid && !tx_ready;
      txst_d = tx_data; txst_l = tx_last;
      if (ev_buf_done)   n_buf++;
      if (ev_frame_done) n_frame++;
      if (ev_babble)     n_bab++;
      if (walking)       act_seen = 1'b1;
   end

   task automatic set_desc(input int a, input int flags, input int len, input int ptr);
      mem[widx(a)]     = {16'(flags), 16'(len)};
      mem[widx(a) + 1] = 32'(ptr);
   endtask

   task automatic base_write(input int v);
      @(negedge clk);
      ring_base_wr  = 1'b1;
      ring_base_val = 32'(v);
      @(negedge clk);
      ring_base_wr  = 1'b0;
      mbase = v & ~3;
      mptr  = mbase;
   endtask

   // reference walk built from the requirements
   task automatic model_walk();
      int p, acc, eff, len, ptr;
      logic [15:0] fl;
      for (int i = 0; i < 256; i++) sm[i] = mem[i];
      p = mptr; acc = 0; exp_n = 0; e_buf = 0; e_frame = 0; e_bab = 0;
      exp_first = 32'(p);
      for (int it = 0; it < 64; it++) begin
         fl  = sm[widx(p)][31:16];
         len = int'(sm[widx(p)][15:0]);
         if (!fl[15]) break;
         ptr = int'(sm[widx(p) + 1]);
         eff = len;
         if (acc + len > MAXF) begin
            eff = MAXF - acc;
            e_bab++;
         end
         for (int i = 0; i < eff; i++) begin
            exp_data[exp_n] = pat(ptr + i);
            exp_last[exp_n] = fl[11] && (i == eff - 1);
            exp_n++;
         end
         acc += eff;
         e_buf++;
         if (fl[11]) begin
            e_frame++;
            acc = 0;
         end
         sm[widx(p)] = {fl & 16'h7fff, 16'(len)};
         p = fl[13] ? mbase : p + 8;
      end
      mptr = p;
   endtask

   task automatic run_walk();
      int wd;
      cap_n = 0; n_buf = 0; n_frame = 0; n_bab = 0; seen_req = 1'b0; act_seen = 1'b0;
      @(negedge clk);
      tx_demand = 1'b1;
      @(negedge clk);
      tx_demand = 1'b0;
      wd = 0;
      while (walking && wd < 20000) begin
         @(negedge clk);
         wd++;
      end
      if (wd >= 20000) chk(1'b0, "watchdog R2", wd, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic compare_run(input string tag);
      chk(seen_req && first_addr == exp_first, {tag, " R2/R4 first descriptor address"},
          int'(first_addr), int'(exp_first));
      chk(cap_n == exp_n, {tag, " R5 byte count"}, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++) begin
         chk(cap_data[i] == exp_data[i], {tag, " R5 byte data"}, int'(cap_data[i]), int'(exp_data[i]));
         chk(cap_last[i] == exp_last[i], {tag, " R6 last marker"}, int'(cap_last[i]), int'(exp_last[i]));
      end
      chk(n_buf == e_buf, {tag, " R7 buffer events"}, n_buf, e_buf);
      chk(n_frame == e_frame, {tag, " R8 frame events"}, n_frame, e_frame);
      chk(n_bab == e_bab, {tag, " R9 babble events"}, n_bab, e_bab);
      for (int w = 64; w < 128; w++)
         chk(mem[w] == sm[w], {tag, " R3/R7 descriptor write-back"}, int'(mem[w]), int'(sm[w]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "global watchdog", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int w = 0; w < 256; w++)
         mem[w] = (w < 128) ? 32'h0 : {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
      mptr = 0; mbase = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!walking && !mem_req && !tx_valid, "R1 idle outputs", {walking, mem_req, tx_valid}, 0);
      chk(!ev_buf_done && !ev_frame_done && !ev_babble, "R1 events low",
          {ev_buf_done, ev_frame_done, ev_babble}, 0);

      // R11 base alignment, R2 disabled demand ignored
      base_write(32'h103);
      set_desc(32'h100, 16'h8000, 5, 32'h201);
      set_desc(32'h108, 16'h8800, 3, 32'h30e);
      set_desc(32'h110, 16'h0000, 0, 0);
      ctrl_en = 1'b0;
      cap_n = 0; seen_req = 1'b0; act_seen = 1'b0;
      @(negedge clk); tx_demand = 1'b1; @(negedge clk); tx_demand = 1'b0;
      repeat (20) @(negedge clk);
      chk(!act_seen && !seen_req && cap_n == 0, "R2 demand ignored while disabled",
          {act_seen, seen_req}, 0);
      chk(mem[widx(32'h100)] == 32'h80000005, "R2 descriptor untouched while disabled",
          int'(mem[widx(32'h100)]), 32'h80000005);
      ctrl_en = 1'b1;

      // split frame, stop at descriptor not ready (R11 base 0x100)
      model_walk(); run_walk(); compare_run("split frame R11");

      // R4 resume at stopped descriptor, R10 wrap to base
      set_desc(32'h110, 16'hA800, 6, 32'h243);
      model_walk(); run_walk(); compare_run("resume R4 wrap R10");
      chk(exp_first == 32'h110, "R4 resumes at held descriptor", int'(exp_first), 32'h110);
      set_desc(32'h100, 16'h8800, 2, 32'h2f7);
      model_walk(); run_walk(); compare_run("after wrap R10");
      chk(first_addr == 32'h100, "R10 wrap returned to base", int'(first_addr), 32'h100);

      // R9 clipping inside a multi-buffer frame
      base_write(32'h140);
      set_desc(32'h140, 16'h8000, 20, 32'h280);
      set_desc(32'h148, 16'h8800, 10, 32'h2a0);
      set_desc(32'h150, 16'h8800, 7, 32'h2c1);
      set_desc(32'h158, 16'h0000, 0, 0);
      model_walk(); run_walk(); compare_run("babble R9");
      chk(n_bab == 1, "R9 one babble event", n_bab, 1);

      // R8 running length restarts on a new demand
      base_write(32'h160);
      set_desc(32'h160, 16'h8000, 10, 32'h300);
      set_desc(32'h168, 16'h0000, 0, 0);
      model_walk(); run_walk(); compare_run("partial frame R8");
      set_desc(32'h168, 16'h8800, 20, 32'h320);
      set_desc(32'h170, 16'h0000, 0, 0);
      model_walk(); run_walk(); compare_run("restart length R8");
      chk(n_bab == 0, "R8 no babble after restart", n_bab, 0);

      // zero-length buffer, base write ignored during a walk (R11)
      base_write(32'h1a0);
      set_desc(32'h1a0, 16'h8000, 0, 32'h200);
      set_desc(32'h1a8, 16'h8800, 12, 32'h3a1);
      set_desc(32'h1b0, 16'h8800, 9, 32'h3b5);
      set_desc(32'h1b8, 16'h0000, 0, 0);
      model_walk();
      fork
         run_walk();
         begin
            repeat (8) @(negedge clk);
            ring_base_wr = 1'b1; ring_base_val = 32'h1e0;
            @(negedge clk);
            ring_base_wr = 1'b0;
         end
      join
      compare_run("zero length R7");
      model_walk(); run_walk(); compare_run("base write while walking R11");
      chk(first_addr == 32'h1b8, "R11 walking base write ignored", int'(first_addr), 32'h1b8);

      // sweep of alignment and length, across the frame limit
      for (int off = 0; off < 4; off++) begin
         for (int k = 0; k < 9; k++) begin
            int len;
            len = (k < 6) ? k + 1 : 17 + k;
            base_write(32'h1c0);
            set_desc(32'h1c0, 16'hA800, len, 32'h200 + 40*k + off);
            model_walk(); run_walk(); compare_run("sweep R5 R9");
         end
      end

      chk(hold_err == 0, "R12 request and byte hold", hold_err, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule